// File: doc/BRIEF.md
# Pipelined Credit-Flow Link

This block carries data words from a producer to a consumer across a link whose forward and return directions are both register pipelines of configurable depth. The sending end keeps a count of free slots in the far-end buffer and accepts a word from its producer only while that count is nonzero, or while a returned credit is landing in the same cycle. Every accepted word travels forward through the pipeline into a receive FIFO. Each time the consumer removes a word, a one-cycle credit pulse travels back through the return pipeline and adds one slot to the count.

The forward latency `LF` counts every register from acceptance to the FIFO output: a word accepted in cycle t is visible to an empty-FIFO consumer in cycle t+LF. The return latency `LB` counts the registers from a pop to the sender: a pop in cycle d makes the credit usable in cycle d+LB. With `DEPTH` credits and a consumer that is always ready, the link carries min(1, DEPTH/(LF+LB)) words per cycle. `DEPTH` must therefore be at least LF+LB for one word every cycle. `LF` and `LB` must each be at least 1.

The sender is a three-state machine. SND_FULL means all credits are home. SND_PART means some credits are in flight. SND_DRY means no credit is held. The count, not the state, decides the next state. Any state goes to SND_FULL when the next count equals `DEPTH`, to SND_DRY when it is zero, and to SND_PART otherwise. In SND_DRY the producer is accepted only during a cycle in which a credit arrives.

Top module: `credit_link`

## Requirements
- R1: Synchronous active-high reset leaves `src_ready` high, `snk_valid` low, and the sender's credit count at `DEPTH`.
- R2: A word is accepted when `src_valid` and `src_ready` are both high. `src_ready` is low exactly when no credit is held and none is arriving in that cycle.
- R3: Suppose a word is accepted in cycle t while the link and FIFO are empty. Then `snk_valid` is low in cycles t+1 to t+LF-1 and high with that word on `snk_data` in cycle t+LF.
- R4: A pop (`snk_valid` and `snk_ready` high) in cycle d on a link with no credit left leaves `src_ready` low in cycle d. `src_ready` rises again in cycle d+LB.
- R5: The credit count never exceeds `DEPTH`. With the consumer stalled, exactly `DEPTH` words are accepted and then `src_ready` stays low.
- R6: The receive FIFO is never written while it holds `DEPTH` words.
- R7: Words leave at `snk_data` in the order they were accepted, none lost or duplicated.
- R8: If a credit arrives in the same cycle a word is accepted, the count is unchanged. With both ends always willing, steady-state throughput is min(1, DEPTH/(LF+LB)) words per cycle.
- R9: The sum of held credits, words in the forward pipeline, words in the FIFO, and credits in the return pipeline always equals `DEPTH`.
- R10: A reset during traffic empties both pipelines and the FIFO and reloads the count, so exactly `DEPTH` words are accepted afterwards against a stalled consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | DW | Producer word |
| src_ready | output | 1 | Sender can take a word this cycle |
| snk_valid | output | 1 | FIFO holds a word for the consumer |
| snk_data | output | DW | Oldest word in the FIFO |
| snk_ready | input | 1 | Consumer takes the word this cycle |

## Verification
The in-line assertions check the following on every cycle: the credit bound, the ban on spending with no credit, the unchanged count when a send and a credit coincide, the absence of FIFO overflow, and the conservation of credits and words over the whole loop. These checks hold whatever the traffic pattern. Only the directed scenarios can show the exact cycle in which a word appears and a credit returns. They also show that delivery stays ordered and complete under random stalls. The measured throughput for three parameter sets matches DEPTH/(LF+LB) capped at one.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
    typedef enum logic [1:0] {
        SND_FULL = 2'd0,
        SND_PART = 2'd1,
        SND_DRY  = 2'd2
    } snd_state_e;
endpackage

// File: rtl/cl_delay_line.sv
module cl_delay_line #(
    parameter int W      = 1,
    parameter int STAGES = 1,
    parameter int OW     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q,
    output logic [OW-1:0] occ
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q   = d;
            assign occ = '0;
        end else begin : g_regs
            logic [W-1:0] stg [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end

            // bit 0 of each stage marks a live entry
            always_comb begin
                occ = '0;
                for (int i = 0; i < STAGES; i++) occ = occ + OW'(stg[i][0]);
            end

            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cl_sender.sv
module cl_sender
    import credit_link_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic          cred_in,
    output logic          send,
    output logic [CW-1:0] cnt
);
    snd_state_e    state, state_nx;
    logic [CW-1:0] cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SND_FULL;
            cnt   <= CW'(DEPTH);
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            SND_FULL: src_ready = 1'b1;
            SND_PART: src_ready = 1'b1;
            SND_DRY:  src_ready = cred_in;
            default:  src_ready = 1'b0;
        endcase
        send = src_valid && src_ready;
    end

    // next count and state
    always_comb begin
        cnt_nx = cnt + CW'(cred_in) - CW'(send);
        if (cnt_nx == CW'(DEPTH))  state_nx = SND_FULL;
        else if (cnt_nx == '0)     state_nx = SND_DRY;
        else                       state_nx = SND_PART;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R5
    AST_NO_DRY_SEND: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !cred_in) |-> !send); // R2
    AST_DRY_STATE: assert property (@(posedge clk) disable iff (rst)
        (state == SND_DRY) |-> (cnt == '0)); // R2
    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (send && cred_in) |=> $stable(cnt)); // R8
endmodule

// File: rtl/cl_rx_fifo.sv
module cl_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    input  logic          rd_ready,
    output logic          pop,
    output logic [LW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign rd_valid = (level != '0);
    assign pop      = rd_valid && rd_ready;
    assign rd_data  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_en) begin
                mem[wp] <= wr_data;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            level <= level + LW'(wr_en) - LW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (level < LW'(DEPTH))); // R6
endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int DW    = 8,
    parameter int LF    = 2,
    parameter int LB    = 1,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic          snk_valid,
    output logic [DW-1:0] snk_data,
    input  logic          snk_ready
);
    localparam int FST = LF - 1;               // FIFO write is the last forward stage
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int FOW = $clog2(FST + 2);
    localparam int BOW = $clog2(LB + 2);

    logic          send, cred, pop;
    logic [CW-1:0] cnt, level;
    logic [DW:0]   fwd_q;
    logic [FOW-1:0] f_occ;
    logic [BOW-1:0] b_occ;

    cl_sender #(.DEPTH(DEPTH), .CW(CW)) u_snd (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
        .cred_in(cred), .send(send), .cnt(cnt)
    );

    cl_delay_line #(.W(DW + 1), .STAGES(FST), .OW(FOW)) u_fwd (
        .clk(clk), .rst(rst), .d({src_data, send}), .q(fwd_q), .occ(f_occ)
    );

    cl_rx_fifo #(.W(DW), .DEPTH(DEPTH), .LW(CW)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(fwd_q[0]), .wr_data(fwd_q[DW:1]),
        .rd_valid(snk_valid), .rd_data(snk_data), .rd_ready(snk_ready),
        .pop(pop), .level(level)
    );

    cl_delay_line #(.W(1), .STAGES(LB), .OW(BOW)) u_bck (
        .clk(clk), .rst(rst), .d(pop), .q(cred), .occ(b_occ)
    );

    AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) + int'(f_occ) + int'(level) + int'(b_occ)) == DEPTH); // R9
endmodule

// File: tb/tb_credit_link.sv
module tb_credit_link;
    localparam int DW = 8;
    localparam int LFV[3] = '{2, 2, 1};
    localparam int LBV[3] = '{1, 2, 2};
    localparam int DPV[3] = '{4, 2, 1};

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst = 1'b1;

    logic          sv[3], sr[3], kv[3], kr[3];
    logic [DW-1:0] sd[3], kd[3];

    credit_link #(.DW(DW), .LF(2), .LB(1), .DEPTH(4)) dut (
        .clk(clk), .rst(rst), .src_valid(sv[0]), .src_data(sd[0]), .src_ready(sr[0]),
        .snk_valid(kv[0]), .snk_data(kd[0]), .snk_ready(kr[0]));
    credit_link #(.DW(DW), .LF(2), .LB(2), .DEPTH(2)) dut_b (
        .clk(clk), .rst(rst), .src_valid(sv[1]), .src_data(sd[1]), .src_ready(sr[1]),
        .snk_valid(kv[1]), .snk_data(kd[1]), .snk_ready(kr[1]));
    credit_link #(.DW(DW), .LF(1), .LB(2), .DEPTH(1)) dut_c (
        .clk(clk), .rst(rst), .src_valid(sv[2]), .src_data(sd[2]), .src_ready(sr[2]),
        .snk_valid(kv[2]), .snk_data(kd[2]), .snk_ready(kr[2]));

    int total = 0, bad = 0;
    int sent_n[3], recv_n[3], win[3];

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock cycle: score at the falling edge, return just after the rising edge
    task automatic cyc();
        for (int k = 0; k < 3; k++) sd[k] = DW'(sent_n[k]);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            if (kv[k] && kr[k]) begin
                chk(kd[k] == DW'(recv_n[k]), "R7 order", int'(kd[k]), recv_n[k] % 256);
                recv_n[k]++;
                win[k]++;
            end
            if (sv[k] && sr[k]) sent_n[k]++;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        for (int k = 0; k < 3; k++) begin
            sent_n[k] = 0; recv_n[k] = 0; win[k] = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b0; kr[k] = 1'b0; end
        cyc();
        cyc();
        rst = 1'b0;
        clear_counts();
    endtask

    task automatic t_reset();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            chk(sr[k] == 1'b1, "R1 src_ready", int'(sr[k]), 1);
            chk(kv[k] == 1'b0, "R1 snk_valid", int'(kv[k]), 0);
        end
    endtask

    task automatic t_latency();
        do_reset();
        for (int k = 0; k < 3; k++) sv[k] = 1'b1;
        cyc();
        for (int k = 0; k < 3; k++) sv[k] = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            for (int k = 0; k < 3; k++)
                chk(kv[k] == (c >= LFV[k]), "R3 arrival cycle", int'(kv[k]), int'(c >= LFV[k]));
            if (c < 3) cyc();
        end
        for (int k = 0; k < 3; k++) chk(kd[k] == 8'd0, "R3 data", int'(kd[k]), 0);
    endtask

    task automatic t_fill();
        do_reset();
        sv[0] = 1'b1;
        repeat (8) cyc();
        chk(sent_n[0] == 4, "R5 accepted with stalled sink", sent_n[0], 4);
        chk(sr[0] == 1'b0, "R2 no credit", int'(sr[0]), 0);
        kr[0] = 1'b1;
        chk(sr[0] == 1'b0, "R4 no credit in pop cycle", int'(sr[0]), 0);
        cyc();
        kr[0] = 1'b0;
        chk(sr[0] == 1'b1, "R4 credit back after LB", int'(sr[0]), 1);
        cyc();
        chk(sent_n[0] == 5, "R4 returned credit spent", sent_n[0], 5);
        chk(sr[0] == 1'b0, "R2 dry again", int'(sr[0]), 0);
        sv[0] = 1'b0;
    endtask

    task automatic t_midreset();
        do_reset();
        sv[0] = 1'b1;
        repeat (3) cyc();
        sv[0] = 1'b0;
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        clear_counts();
        chk(sr[0] == 1'b1, "R10 src_ready after reset", int'(sr[0]), 1);
        chk(kv[0] == 1'b0, "R10 fifo emptied", int'(kv[0]), 0);
        sv[0] = 1'b1;
        repeat (8) cyc();
        chk(sent_n[0] == 4, "R10 credits reloaded", sent_n[0], 4);
        chk(kv[0] == 1'b1, "R10 words delivered", int'(kv[0]), 1);
        sv[0] = 1'b0;
    endtask

    // random stalls on both ends; R6 and R9 are watched by the design's assertions
    task automatic t_random();
        do_reset();
        repeat (600) begin
            for (int k = 0; k < 3; k++) begin
                sv[k] = 1'($urandom % 2);
                kr[k] = (($urandom % 4) != 0);
            end
            cyc();
        end
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b0; kr[k] = 1'b1; end
        repeat (30) cyc();
        for (int k = 0; k < 3; k++) begin
            chk(recv_n[k] == sent_n[k], "R7 lossless", recv_n[k], sent_n[k]);
            chk(sent_n[k] > 50, "R7 traffic moved", sent_n[k], 51);
        end
    endtask

    task automatic t_throughput();
        do_reset();
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b1; kr[k] = 1'b1; end
        repeat (40) cyc();
        for (int k = 0; k < 3; k++) win[k] = 0;
        repeat (240) cyc();
        for (int k = 0; k < 3; k++) begin
            int rt = LFV[k] + LBV[k];
            int ex = (DPV[k] >= rt) ? 240 : (240 * DPV[k]) / rt;
            int df = win[k] - ex;
            chk(df <= 1 && df >= -1, "R8 throughput", win[k], ex);
        end
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b0; kr[k] = 1'b0; end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b0; kr[k] = 1'b0; sd[k] = '0; end
        clear_counts();
        t_reset();
        t_latency();
        t_fill();
        t_midreset();
        t_random();
        t_throughput();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL run-time limit: actual=100000 cycles expected=fewer");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule